// File: doc/BRIEF.md
# Gamma Line Latch with Polarity Tap Selection

This block sits between a column driver's line data register and its digital-to-analog stage. When the latch strobe rises, it copies one line of 8-bit gray codes into a line latch, one code per channel, and records the polarity input at the same moment. For every channel it then describes in digital form the level the output should drive. The description has four parts: a reference bank, a segment of the gamma reference ladder, a tap numerator and denominator inside that segment, and a 16-bit fixed-point fraction equal to numerator × 65536 / denominator, rounded down.

The gamma split is piecewise and not uniform. Six interpolating segments have different step weights, and the two highest codes select a ladder end point directly. The lower bank mirrors the upper bank, so the segment, numerator and denominator do not depend on the bank. Neighbouring channels always take opposite banks, and the polarity input decides which parity gets which bank. While the strobe is high, every channel reports high impedance. In narrow mode a fixed run of channels stays high impedance. The bank alternation keeps counting those channels, so the channels after the run do not shift their polarity.

Top module: `gamma_line_latch`

## Requirements
- R1: After reset, every channel reports high impedance with bank, segment, numerator, denominator and fraction all zero. This holds until the first complete strobe pulse.
- R2: The line codes and the polarity are captured only on the clock edge where `strobe` is first seen high. Changes to `line_codes` or `pol` at any other time leave the outputs unchanged.
- R3: In the cycle after `strobe` is sampled high, every channel reports high impedance, and every field of a high-impedance channel reads zero. Channels drive the latched line from the cycle after `strobe` is first sampled low.
- R4: Bank 1 is the lower bank and bank 0 the upper bank. Channel index i has physical number i+1. With captured polarity 1, odd physical channels (even i) use bank 1 and even physical channels use bank 0. With captured polarity 0 the assignment is swapped.
- R5: Codes 0x00–0x1F give segment 0, numerator 218·k with k = code, denominator 6976 and fraction k·2048. Codes 0x20–0x3F give segment 1, numerator 70·k with k = code−0x20, denominator 2240 and fraction k·2048.
- R6: Codes 0x40–0x7F give segment 2 and codes 0x80–0xBF give segment 3. In both, k is the offset from the range start, the numerator is 32·k, the denominator is 2048 and the fraction is k·1024.
- R7: Codes 0xC0–0xEF give segment 4, numerator 50·k, denominator 2400 and fraction floor(k·65536/48). Codes 0xF0–0xFD give segment 5, numerator 200·k, denominator 2800 and fraction floor(k·65536/14).
- R8: Code 0xFE gives segment 6 and code 0xFF gives segment 7. Both are ladder end points, with numerator 0, denominator 1 and fraction 0.
- R9: While `narrow` is high, channels GAP_FIRST to GAP_FIRST+GAP_COUNT−1 report high impedance with all fields zero. The bank of every other channel still follows its physical number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe | input | 1 | Line latch strobe, sampled on clk |
| pol | input | 1 | Polarity select, captured on the strobe rise |
| narrow | input | 1 | Narrow mode; the gap channels are disabled |
| line_codes | input | NCH*8 | Filled line data register, channel i at bits [8i+7:8i] |
| ch_hiz | output | NCH | Per-channel high-impedance flag |
| ch_bank | output | NCH | Per-channel bank, 1 = lower |
| ch_seg | output | NCH*3 | Per-channel segment index |
| ch_num | output | NCH*13 | Per-channel tap numerator |
| ch_den | output | NCH*13 | Per-channel segment denominator |
| ch_wt | output | NCH*16 | Per-channel fraction numerator·65536/denominator |

## Verification
The bench walks both ends of every segment and one code inside several of them, including codes whose fraction has to be rounded down. A design with a wrong range boundary or a wrong step weight reports the wrong segment or numerator there. A divider that rounds up or off shows up at 0xC1, 0xEF, 0xF1 and 0xFD. The bench changes the codes and the polarity between strobe pulses, which catches a latch that is transparent or that tracks `pol` live. Running narrow mode with the polarity set shows whether the gap channels are kept quiet, and whether a design renumbers the channels after the gap and so flips their banks.

// File: rtl/gtl_pkg.sv
package gtl_pkg;
    localparam int CODE_W = 8;
    localparam int SEG_W  = 3;
    localparam int TAP_W  = 13;
    localparam int WT_W   = 16;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [TAP_W-1:0] num;
        logic [TAP_W-1:0] den;
        logic [WT_W-1:0]  wt;
    } lvl_t;
endpackage

// File: rtl/gtl_tap_decode.sv
module gtl_tap_decode
    import gtl_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output lvl_t              lvl
);
    logic [5:0]  k;
    logic [21:0] kshift;

    assign kshift = {k, 16'b0};

    always_comb begin
        k   = '0;
        lvl = '0;
        if (code[7:5] == 3'b000) begin
            k       = {1'b0, code[4:0]};
            lvl.seg = 3'd0;
            lvl.num = {7'd0, k} * 13'd218;
            lvl.den = 13'd6976;
            lvl.wt  = {k[4:0], 11'b0};
        end else if (code[7:5] == 3'b001) begin
            k       = {1'b0, code[4:0]};
            lvl.seg = 3'd1;
            lvl.num = {7'd0, k} * 13'd70;
            lvl.den = 13'd2240;
            lvl.wt  = {k[4:0], 11'b0};
        end else if (code[7:6] == 2'b01 || code[7:6] == 2'b10) begin
            k       = code[5:0];
            lvl.seg = code[7] ? 3'd3 : 3'd2;
            lvl.num = {7'd0, k} * 13'd32;
            lvl.den = 13'd2048;
            lvl.wt  = {k, 10'b0};
        end else if (code < 8'hF0) begin
            k       = code[5:0];
            lvl.seg = 3'd4;
            lvl.num = {7'd0, k} * 13'd50;
            lvl.den = 13'd2400;
            lvl.wt  = 16'(kshift / 22'd48);
        end else if (code < 8'hFE) begin
            k       = {2'b0, code[3:0]};
            lvl.seg = 3'd5;
            lvl.num = {7'd0, k} * 13'd200;
            lvl.den = 13'd2800;
            lvl.wt  = 16'(kshift / 22'd14);
        end else begin
            lvl.seg = code[0] ? 3'd7 : 3'd6;
            lvl.den = 13'd1;
        end
    end
endmodule

// File: rtl/gtl_line_latch.sv
module gtl_line_latch
    import gtl_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strobe,
    input  logic                  pol,
    input  logic [NCH*CODE_W-1:0] line_codes,
    output logic [NCH*CODE_W-1:0] codes_l,
    output logic                  pol_l,
    output logic                  hiz_l
);
    typedef struct packed {
        logic                  strb;
        logic                  loaded;
        logic                  hiz;
        logic                  pol;
        logic [NCH*CODE_W-1:0] codes;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.strb = strobe;
        if (strobe && !st_q.strb) begin
            st_d.codes  = line_codes;
            st_d.pol    = pol;
            st_d.loaded = 1'b1;
        end
        st_d.hiz = strobe || !st_d.loaded;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.hiz <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign codes_l = st_q.codes;
    assign pol_l   = st_q.pol;
    assign hiz_l   = st_q.hiz;
endmodule

// File: rtl/gtl_chan_out.sv
module gtl_chan_out
    import gtl_pkg::*;
#(
    parameter int IDX       = 0,
    parameter int GAP_FIRST = 6,
    parameter int GAP_COUNT = 2
) (
    input  logic hiz_l,
    input  logic pol_l,
    input  logic narrow,
    input  lvl_t lvl_in,
    output logic hiz,
    output logic bank,
    output lvl_t lvl_out
);
    localparam bit PHYS_ODD = (IDX % 2) == 0;
    localparam bit IN_GAP   = (IDX >= GAP_FIRST) && (IDX < GAP_FIRST + GAP_COUNT);

    always_comb begin
        hiz     = hiz_l || (narrow && IN_GAP);
        bank    = hiz ? 1'b0 : (PHYS_ODD ? pol_l : !pol_l);
        lvl_out = hiz ? '0 : lvl_in;
    end
endmodule

// File: rtl/gamma_line_latch.sv
module gamma_line_latch
    import gtl_pkg::*;
#(
    parameter int NCH       = 12,
    parameter int GAP_FIRST = 6,
    parameter int GAP_COUNT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe,
    input  logic                 pol,
    input  logic                 narrow,
    input  logic [NCH*8-1:0]     line_codes,
    output logic [NCH-1:0]       ch_hiz,
    output logic [NCH-1:0]       ch_bank,
    output logic [NCH*3-1:0]     ch_seg,
    output logic [NCH*13-1:0]    ch_num,
    output logic [NCH*13-1:0]    ch_den,
    output logic [NCH*16-1:0]    ch_wt
);
    logic [NCH*CODE_W-1:0] codes_l;
    logic                  pol_l;
    logic                  hiz_l;

    gtl_line_latch #(.NCH(NCH)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .pol        (pol),
        .line_codes (line_codes),
        .codes_l    (codes_l),
        .pol_l      (pol_l),
        .hiz_l      (hiz_l)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        lvl_t dec;
        lvl_t drv;

        gtl_tap_decode u_dec (
            .code (codes_l[i*CODE_W +: CODE_W]),
            .lvl  (dec)
        );

        gtl_chan_out #(.IDX(i), .GAP_FIRST(GAP_FIRST), .GAP_COUNT(GAP_COUNT)) u_out (
            .hiz_l   (hiz_l),
            .pol_l   (pol_l),
            .narrow  (narrow),
            .lvl_in  (dec),
            .hiz     (ch_hiz[i]),
            .bank    (ch_bank[i]),
            .lvl_out (drv)
        );

        assign ch_seg[i*SEG_W +: SEG_W] = drv.seg;
        assign ch_num[i*TAP_W +: TAP_W] = drv.num;
        assign ch_den[i*TAP_W +: TAP_W] = drv.den;
        assign ch_wt[i*WT_W +: WT_W]    = drv.wt;
    end
endmodule

// File: rtl/gamma_line_latch_chk.sv
module gamma_line_latch_chk #(
    parameter int NCH       = 12,
    parameter int GAP_FIRST = 6,
    parameter int GAP_COUNT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic              narrow,
    input logic [NCH-1:0]    ch_hiz,
    input logic [NCH-1:0]    ch_bank,
    input logic [NCH*13-1:0] ch_num,
    input logic [NCH*13-1:0] ch_den
);
    // R3
    strobe_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (&ch_hiz));

    // R9
    gap_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> (&ch_hiz[GAP_FIRST +: GAP_COUNT]));

    // R2
    hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !$past(strobe)) |=>
            (!$stable(narrow) || ($stable(ch_num) && $stable(ch_bank) && $stable(ch_hiz))));

    // R4
    bank_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_hiz[0] && !ch_hiz[1]) |-> (ch_bank[0] != ch_bank[1]));

    for (genvar i = 0; i < NCH; i++) begin : g_rng
        // R5
        num_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_hiz[i] |-> (ch_num[i*13 +: 13] < ch_den[i*13 +: 13]));
    end
endmodule

bind gamma_line_latch gamma_line_latch_chk #(
    .NCH(NCH), .GAP_FIRST(GAP_FIRST), .GAP_COUNT(GAP_COUNT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .narrow  (narrow),
    .ch_hiz  (ch_hiz),
    .ch_bank (ch_bank),
    .ch_num  (ch_num),
    .ch_den  (ch_den)
);

// File: tb/sim_gamma_line_latch.sv
module sim_gamma_line_latch;
    localparam int NCH = 12;
    localparam int GF  = 6;
    localparam int GC  = 2;
    localparam int NV  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe = 1'b0;
    logic              pol = 1'b0;
    logic              narrow = 1'b0;
    logic [NCH*8-1:0]  line_codes = '0;
    logic [NCH-1:0]    ch_hiz, ch_bank;
    logic [NCH*3-1:0]  ch_seg;
    logic [NCH*13-1:0] ch_num, ch_den;
    logic [NCH*16-1:0] ch_wt;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    gamma_line_latch #(.NCH(NCH), .GAP_FIRST(GF), .GAP_COUNT(GC)) u0 (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .pol(pol), .narrow(narrow),
        .line_codes(line_codes), .ch_hiz(ch_hiz), .ch_bank(ch_bank),
        .ch_seg(ch_seg), .ch_num(ch_num), .ch_den(ch_den), .ch_wt(ch_wt)
    );

    // {code, seg, num, den, wt}
    localparam logic [52:0] VEC [NV] = '{
        {8'h00, 3'd0, 13'd0,    13'd6976, 16'd0},
        {8'h01, 3'd0, 13'd218,  13'd6976, 16'd2048},
        {8'h1F, 3'd0, 13'd6758, 13'd6976, 16'd63488},
        {8'h20, 3'd1, 13'd0,    13'd2240, 16'd0},
        {8'h3F, 3'd1, 13'd2170, 13'd2240, 16'd63488},
        {8'h40, 3'd2, 13'd0,    13'd2048, 16'd0},
        {8'h7F, 3'd2, 13'd2016, 13'd2048, 16'd64512},
        {8'h80, 3'd3, 13'd0,    13'd2048, 16'd0},
        {8'hA5, 3'd3, 13'd1184, 13'd2048, 16'd37888},
        {8'hC1, 3'd4, 13'd50,   13'd2400, 16'd1365},
        {8'hEF, 3'd4, 13'd2350, 13'd2400, 16'd64170},
        {8'hF0, 3'd5, 13'd0,    13'd2800, 16'd0},
        {8'hF1, 3'd5, 13'd200,  13'd2800, 16'd4681},
        {8'hFD, 3'd5, 13'd2600, 13'd2800, 16'd60854},
        {8'hFE, 3'd6, 13'd0,    13'd1,    16'd0},
        {8'hFF, 3'd7, 13'd0,    13'd1,    16'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [44:0] fields(input int i);
        return {ch_seg[i*3 +: 3], ch_num[i*13 +: 13], ch_den[i*13 +: 13], ch_wt[i*16 +: 16]};
    endfunction

    function automatic logic exp_bank(input int i, input logic p);
        return (i % 2 == 0) ? p : !p;
    endfunction

    // strobe pulse with stimulus corrupted right after the capture edge
    task automatic load_line(input logic [NCH*8-1:0] codes, input logic p);
        @(negedge clk);
        line_codes = codes;
        pol        = p;
        strobe     = 1'b1;
        @(negedge clk);
        // R3: high impedance while strobe high, fields zero
        chk(ch_hiz == '1, "R3", "hiz during strobe", ch_hiz, {NCH{1'b1}});
        chk(ch_num == '0 && ch_wt == '0, "R3", "fields during strobe", ch_num[12:0], 0);
        strobe     = 1'b0;
        line_codes = ~codes;
        pol        = !p;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NCH*8-1:0] mixed;
        logic [44:0]      snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(ch_hiz == '1, "R1", "hiz after reset", ch_hiz, {NCH{1'b1}});
        chk(ch_num == '0 && ch_den == '0 && ch_wt == '0 && ch_bank == '0 && ch_seg == '0,
            "R1", "fields after reset", ch_den[12:0], 0);

        // table walk: R5 R6 R7 R8 and R4
        for (int v = 0; v < NV; v++) begin
            logic p;
            p = v[0];
            load_line({NCH{VEC[v][52:45]}}, p);
            for (int i = 0; i < NCH; i++) begin
                chk(fields(i) == VEC[v][44:0], "R5/R6/R7/R8", $sformatf("code %0h ch%0d", VEC[v][52:45], i),
                    fields(i), VEC[v][44:0]);
                chk(ch_bank[i] == exp_bank(i, p), "R4", $sformatf("bank ch%0d", i),
                    ch_bank[i], exp_bank(i, p));
            end
            chk(ch_hiz == '0, "R3", "driven after strobe", ch_hiz, 0);
        end

        // mixed line: codes i*23
        for (int i = 0; i < NCH; i++) mixed[i*8 +: 8] = 8'(i * 23);
        load_line(mixed, 1'b1);
        chk(fields(11) == {3'd5, 13'd2600, 13'd2800, 16'd60854}, "R7", "mixed ch11",
            fields(11), {3'd5, 13'd2600, 13'd2800, 16'd60854});
        chk(fields(9) == {3'd4, 13'd750, 13'd2400, 16'd20480}, "R7", "mixed ch9",
            fields(9), {3'd4, 13'd750, 13'd2400, 16'd20480});

        // R2: stimulus changes without strobe have no effect
        snap = fields(11);
        @(negedge clk);
        line_codes = '0;
        pol        = 1'b0;
        repeat (3) @(negedge clk);
        chk(fields(11) == snap, "R2", "ch11 held", fields(11), snap);
        chk(ch_bank[0] == 1'b1 && ch_bank[1] == 1'b0, "R2", "bank held", ch_bank[1:0], 2'b01);

        // R9: narrow mode gap and unshifted alternation
        narrow = 1'b1;
        @(negedge clk);
        chk(ch_hiz[GF +: GC] == '1, "R9", "gap hiz", ch_hiz[GF +: GC], 2'b11);
        chk(fields(6) == '0 && fields(7) == '0, "R9", "gap fields", fields(6), 0);
        chk(ch_hiz[5] == 1'b0 && ch_hiz[8] == 1'b0, "R9", "neighbours driven", {ch_hiz[8], ch_hiz[5]}, 0);
        chk(ch_bank[5] == 1'b0, "R9", "bank ch5", ch_bank[5], 0);
        chk(ch_bank[8] == 1'b1, "R9", "bank ch8", ch_bank[8], 1);
        chk(fields(11) == snap, "R9", "ch11 after gap", fields(11), snap);
        narrow = 1'b0;
        @(negedge clk);
        chk(ch_hiz == '0, "R9", "gap released", ch_hiz, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule